// File: doc/BRIEF.md
# Nibble-Addressed DAC Bus Write Sequencer

This block sits on the host side of a parallel-input 10-bit DAC whose input register is split into three 4-bit nibbles, each picked by two address lines. A client presents a 10-bit code and a mode and pulses `start`. The sequencer appends two zero sub-LSB bits to form a 12-bit word. It then drives chip select, write strobe, the two address lines, an 8-bit data bus and the active-low load strobe. Every setup, strobe width, hold and gap is a whole number of system-clock cycles, rounded up from nanosecond minimums given as parameters.

Three transfer styles are supported. The nibble style makes three 4-bit writes and then a load pulse. The byte-with-pulse style makes two writes, low and middle nibble as one byte and then the high nibble, and then a load pulse. The byte-transparent style holds the load strobe low across both writes and releases it only after a tail time. `busy` covers the whole sequence, and `done` marks its end for one cycle.

Top module: `nib_dac_writer`

## Requirements
- R1: After synchronous reset `cs_n`, `wr_n` and `ld_n` are 1; `busy`, `done`, `a0`, `a1` and `bus_d` are 0.
- R2: The word sent is W = {code, 2'b00}. A nibble write carries its nibble on `bus_d[3:0]`, with `bus_d[7:4]` = 0. The byte write carries W[7:0].
- R3: Mode 0 (nibble style) makes three writes in this order: W[11:8] with a0=1,a1=1; W[7:4] with a0=1,a1=0; W[3:0] with a0=0,a1=1. `ld_n` stays high during the writes. Then follows one `ld_n` low pulse of C_LD = ceil(LD_PULSE_NS/T) cycles.
- R4: Mode 1 (byte with pulse) makes two writes: W[7:0] with a0=a1=0, then W[11:8] with a0=a1=1. `ld_n` stays high during both writes. Then follows one `ld_n` low pulse of C_LD cycles.
- R5: Mode 2 (byte transparent) makes the same two writes in the same order as mode 1. `ld_n` falls with `cs_n` of the first write and stays low through both writes. After the last hold it stays low for C_LT = ceil(LD_TAIL_NS/T) more cycles, giving one pulse as long as the whole sequence.
- R6: Mode 3 behaves exactly as mode 0.
- R7: For every write, `cs_n` falls with address and data already valid. `wr_n` falls C_SU = max(1, ceil(ADDR_SETUP_NS/T), ceil(DATA_SETUP_NS/T) - C_WR) cycles later and stays low for C_WR = ceil(WR_PULSE_NS/T) cycles. `cs_n`, address and data then hold for C_HD = max(1, ceil(ADDR_HOLD_NS/T)) cycles. Address and data never change and `wr_n` is never low while `cs_n` is high.
- R8: Exactly C_GAP cycles with `cs_n` high separate consecutive writes. The same gap separates the last write from the load pulse in modes 0 and 1.
- R9: `start` is sampled only while idle, and `busy` is 1 in the cycle after it is accepted. Mode and code are captured at that moment. A `start` raised while busy is ignored.
- R10: `busy` is high for exactly N*(C_SU+C_WR+C_HD) + (N-1)*C_GAP + E cycles, where N is the write count and E is C_GAP+C_LD (modes 0, 1, 3) or C_LT (mode 2). `done` is high for exactly one cycle, the first cycle with `busy` low.
- R11: Between sequences `cs_n`, `wr_n` and `ld_n` stay 1, and `bus_d`, `a0` and `a1` keep the last written values. A `start` given in the `done` cycle is accepted, so `busy` is low for only that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a transfer (sampled when idle) |
| mode | input | 2 | Transfer style: 0 nibble, 1 byte with pulse, 2 byte transparent, 3 as 0 |
| code | input | 10 | DAC code to send |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence marker |
| cs_n | output | 1 | DAC chip select, active low |
| wr_n | output | 1 | DAC write strobe, active low |
| a0 | output | 1 | Nibble address bit 0 |
| a1 | output | 1 | Nibble address bit 1 |
| bus_d | output | 8 | DAC data bus |
| ld_n | output | 1 | DAC load strobe, active low |

## Verification
Two functions can land in the same cycle. The end of one sequence (`done` high, `busy` low) can coincide with the acceptance of the next `start`, and in mode 2 a write strobe can overlap a load strobe that is already low. The bench provokes the first by raising `start` in the very negedge where it sees `done`. It then requires `busy` high at the next sample and the second word's writes to appear unaltered. The overlap is judged by recording, at each write strobe's rising edge, whether `ld_n` was low, and comparing against zero writes in modes 0, 1 and 3 and two in mode 2. A `start` with a different mode and code is also held high in mid-sequence, and the recorded bus must still match the first request.

// File: rtl/dacseq_pkg.sv
// Shared types and cycle-count helpers for the nibble DAC write sequencer.
// Assumes a 10-bit code padded with two zero sub-LSB bits to a 12-bit word.
package dacseq_pkg;

    localparam int CODE_W  = 10;
    localparam int WORD_W  = CODE_W + 2;
    localparam int NIBBLES = WORD_W / 4;

    typedef enum logic [1:0] {
        MODE_NIB         = 2'd0,
        MODE_BYTE_PULSE  = 2'd1,
        MODE_BYTE_TRANSP = 2'd2,
        MODE_ALT         = 2'd3
    } seq_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_GAP,
        PH_LOAD,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic       a1;
        logic       a0;
        logic [7:0] data;
    } bus_word_t;

    // Rounds a nanosecond minimum up to whole clock cycles.
    function automatic int cyc_ceil(int ns, int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacseq_span_timer.sv
// Loadable down-counter timing one bus phase.
// A load of length N makes `last` true in the N-th cycle of the phase.
// Assumes N >= 1.
module dacseq_span_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt_q;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/dacseq_slot_map.sv
// Maps (mode, write slot, word) to the address bits and data byte of one write.
// Nibble style: high, middle, low. Byte styles: low+middle byte, then high.
module dacseq_slot_map
    import dacseq_pkg::*;
(
    input  seq_mode_e         mode,
    input  logic [1:0]        slot,
    input  logic [WORD_W-1:0] word,
    output bus_word_t         bw
);
    logic [3:0] nib [NIBBLES];

    for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
        assign nib[n] = word[4*n +: 4];
    end

    // Select address and data for the requested slot.
    always_comb begin
        bw = '0;
        if (mode == MODE_BYTE_PULSE || mode == MODE_BYTE_TRANSP) begin
            if (slot == 2'd0) begin
                bw = '{a1: 1'b0, a0: 1'b0, data: {nib[1], nib[0]}};
            end else begin
                bw = '{a1: 1'b1, a0: 1'b1, data: {4'h0, nib[2]}};
            end
        end else begin
            unique case (slot)
                2'd0:    bw = '{a1: 1'b1, a0: 1'b1, data: {4'h0, nib[2]}};
                2'd1:    bw = '{a1: 1'b0, a0: 1'b1, data: {4'h0, nib[1]}};
                default: bw = '{a1: 1'b1, a0: 1'b0, data: {4'h0, nib[0]}};
            endcase
        end
    end

endmodule

// File: rtl/dacseq_fsm.sv
// Phase sequencer for the DAC bus. Steps setup/strobe/hold/gap per write, then
// the load pulse or transparent tail. All bus outputs are registered from the
// next phase so that they change only on clock edges.
// Assumes every cycle count parameter is >= 1.
module dacseq_fsm
    import dacseq_pkg::*;
#(
    parameter int C_SU  = 1,
    parameter int C_WR  = 9,
    parameter int C_HD  = 1,
    parameter int C_GAP = 1,
    parameter int C_LD  = 9,
    parameter int C_LT  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [CODE_W-1:0] code,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              wr_n,
    output logic              a0,
    output logic              a1,
    output logic [7:0]        bus_d,
    output logic              ld_n
);
    localparam int C_MAX = imax(imax(imax(C_SU, C_WR), imax(C_HD, C_GAP)), imax(C_LD, C_LT));
    localparam int TW    = $clog2(C_MAX + 1);
    localparam logic [TW-1:0] L_SU  = TW'(C_SU);
    localparam logic [TW-1:0] L_WR  = TW'(C_WR);
    localparam logic [TW-1:0] L_HD  = TW'(C_HD);
    localparam logic [TW-1:0] L_GAP = TW'(C_GAP);
    localparam logic [TW-1:0] L_LD  = TW'(C_LD);
    localparam logic [TW-1:0] L_LT  = TW'(C_LT);

    phase_e            ph_q, ph_d;
    logic [1:0]        slot_q, slot_d;
    seq_mode_e         mode_q, mode_d, mode_in;
    logic [WORD_W-1:0] word_q, map_word;
    logic              tmr_load, tmr_last, fin, last_slot;
    logic [TW-1:0]     tmr_len;
    bus_word_t         map_bw;

    // Mode 3 is folded onto the nibble style at capture.
    assign mode_in   = (mode == 2'd3) ? MODE_NIB : seq_mode_e'(mode);
    assign mode_d    = (ph_q == PH_IDLE) ? mode_in : mode_q;
    assign map_word  = (ph_q == PH_IDLE) ? {code, 2'b00} : word_q;
    assign last_slot = (mode_q == MODE_NIB) ? (slot_q == 2'd2) : (slot_q == 2'd1);

    dacseq_span_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    dacseq_slot_map u_map (
        .mode (mode_d),
        .slot (slot_d),
        .word (map_word),
        .bw   (map_bw)
    );

    // Next-phase decision and timer reload.
    always_comb begin
        ph_d     = ph_q;
        slot_d   = slot_q;
        tmr_load = 1'b0;
        tmr_len  = L_SU;
        fin      = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (start) begin
                ph_d = PH_SETUP; slot_d = 2'd0; tmr_load = 1'b1; tmr_len = L_SU;
            end
            PH_SETUP: if (tmr_last) begin
                ph_d = PH_STROBE; tmr_load = 1'b1; tmr_len = L_WR;
            end
            PH_STROBE: if (tmr_last) begin
                ph_d = PH_HOLD; tmr_load = 1'b1; tmr_len = L_HD;
            end
            PH_HOLD: if (tmr_last) begin
                tmr_load = 1'b1;
                if (last_slot && mode_q == MODE_BYTE_TRANSP) begin
                    ph_d = PH_TAIL; tmr_len = L_LT;
                end else begin
                    ph_d = PH_GAP; tmr_len = L_GAP;
                end
            end
            PH_GAP: if (tmr_last) begin
                tmr_load = 1'b1;
                if (last_slot) begin
                    ph_d = PH_LOAD; tmr_len = L_LD;
                end else begin
                    ph_d = PH_SETUP; slot_d = slot_q + 2'd1; tmr_len = L_SU;
                end
            end
            PH_LOAD, PH_TAIL: if (tmr_last) begin
                ph_d = PH_IDLE; fin = 1'b1;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase, capture and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            slot_q <= 2'd0;
            mode_q <= MODE_NIB;
            word_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            cs_n   <= 1'b1;
            wr_n   <= 1'b1;
            ld_n   <= 1'b1;
            a0     <= 1'b0;
            a1     <= 1'b0;
            bus_d  <= '0;
        end else begin
            ph_q   <= ph_d;
            slot_q <= slot_d;
            if (ph_q == PH_IDLE && start) begin
                mode_q <= mode_in;
                word_q <= {code, 2'b00};
            end
            busy <= (ph_d != PH_IDLE);
            done <= fin;
            cs_n <= !(ph_d == PH_SETUP || ph_d == PH_STROBE || ph_d == PH_HOLD);
            wr_n <= (ph_d != PH_STROBE);
            ld_n <= !(ph_d == PH_LOAD ||
                      (mode_d == MODE_BYTE_TRANSP && ph_d != PH_IDLE));
            if (ph_d == PH_SETUP && ph_q != PH_SETUP) begin
                a1    <= map_bw.a1;
                a0    <= map_bw.a0;
                bus_d <= map_bw.data;
            end
        end
    end

    // Checker counter: length of the current write strobe.
    logic [TW:0] wr_low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_low_cnt <= '0;
        else if (!wr_n)  wr_low_cnt <= wr_low_cnt + 1'b1;
        else             wr_low_cnt <= '0;
    end

    p_wr_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);
    p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(bus_d) && $stable(a0) && $stable(a1)));
    p_wr_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (wr_low_cnt == (TW+1)'(C_WR)));
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ld_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !wr_n) |-> (mode_q == MODE_BYTE_TRANSP));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && wr_n && ld_n));

endmodule

// File: rtl/nib_dac_writer.sv
// Top of the host-side DAC write sequencer. Converts nanosecond bus minimums
// into cycle counts for the given clock period and hosts the phase sequencer.
// Assumes the DAC samples on the write-strobe and load-strobe rising edges.
module nib_dac_writer
    import dacseq_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int ADDR_SETUP_NS = 5,
    parameter int ADDR_HOLD_NS  = 5,
    parameter int DATA_SETUP_NS = 45,
    parameter int WR_PULSE_NS   = 45,
    parameter int LD_PULSE_NS   = 45,
    parameter int LD_TAIL_NS    = 50,
    parameter int GAP_CYCLES    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  mode,
    input  logic [9:0]  code,
    output logic        busy,
    output logic        done,
    output logic        cs_n,
    output logic        wr_n,
    output logic        a0,
    output logic        a1,
    output logic [7:0]  bus_d,
    output logic        ld_n
);
    localparam int C_WR  = imax(1, cyc_ceil(WR_PULSE_NS, CLK_PERIOD_NS));
    localparam int C_SU  = imax(imax(1, cyc_ceil(ADDR_SETUP_NS, CLK_PERIOD_NS)),
                                cyc_ceil(DATA_SETUP_NS, CLK_PERIOD_NS) - C_WR);
    localparam int C_HD  = imax(1, cyc_ceil(ADDR_HOLD_NS, CLK_PERIOD_NS));
    localparam int C_LD  = imax(1, cyc_ceil(LD_PULSE_NS, CLK_PERIOD_NS));
    localparam int C_LT  = imax(1, cyc_ceil(LD_TAIL_NS, CLK_PERIOD_NS));
    localparam int C_GAP = imax(1, GAP_CYCLES);

    dacseq_fsm #(
        .C_SU  (C_SU),
        .C_WR  (C_WR),
        .C_HD  (C_HD),
        .C_GAP (C_GAP),
        .C_LD  (C_LD),
        .C_LT  (C_LT)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mode  (mode),
        .code  (code),
        .busy  (busy),
        .done  (done),
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .a0    (a0),
        .a1    (a1),
        .bus_d (bus_d),
        .ld_n  (ld_n)
    );

endmodule

// File: tb/test_nib_dac_writer.sv
module test_nib_dac_writer;
    localparam int T_NS = 5;
    // Cycle counts derived from the requirement formulas (default nanoseconds).
    localparam int E_WR  = (45 + T_NS - 1) / T_NS;
    localparam int E_SU  = ((45 + T_NS - 1) / T_NS - E_WR > 1) ? (45 + T_NS - 1) / T_NS - E_WR : 1;
    localparam int E_HD  = 1;
    localparam int E_GAP = 1;
    localparam int E_LD  = (45 + T_NS - 1) / T_NS;
    localparam int E_LT  = (50 + T_NS - 1) / T_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [9:0] code = '0;
    logic busy, done, cs_n, wr_n, a0, a1, ld_n;
    logic [7:0] bus_d;

    always #2.5 clk = ~clk;

    nib_dac_writer i_nib_dac_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .code(code),
        .busy(busy), .done(done), .cs_n(cs_n), .wr_n(wr_n), .a0(a0), .a1(a1),
        .bus_d(bus_d), .ld_n(ld_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Monitor records (sampled 2 ns after each rising edge).
    int nwr, busy_cnt, done_cnt, viol, ld_cnt, ld_len, ldlow_wr;
    int hi_run = 0, wr_run = 0, ld_run = 0;
    logic [1:0] a_rec [8];
    logic [7:0] d_rec [8];
    int su_rec [8], hd_rec [8], wr_rec [8];
    logic p_cs_n = 1'b1, p_wr_n = 1'b1, p_ld_n = 1'b1;
    logic [9:0] p_bus = '0;

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (!cs_n && !p_cs_n && ({a1, a0, bus_d} != p_bus)) viol++;
            if (!wr_n && cs_n) viol++;
            if (!wr_n) wr_run++;
            else if (!p_wr_n) begin
                if (nwr < 8) begin
                    a_rec[nwr] = {a1, a0};
                    d_rec[nwr] = bus_d;
                    wr_rec[nwr] = wr_run;
                end
                if (!ld_n) ldlow_wr++;
                nwr++;
                wr_run = 0;
            end
            if (p_wr_n && !wr_n) begin
                if (nwr < 8) su_rec[nwr] = hi_run;
                hi_run = 0;
            end else if (!cs_n && wr_n) hi_run++;
            if (cs_n) begin
                if (!p_cs_n && nwr > 0 && nwr <= 8) hd_rec[nwr-1] = hi_run;
                hi_run = 0;
            end
            if (!ld_n) ld_run++;
            else if (!p_ld_n) begin
                ld_len = ld_run;
                ld_cnt++;
                ld_run = 0;
            end
            p_cs_n = cs_n; p_wr_n = wr_n; p_ld_n = ld_n;
            p_bus = {a1, a0, bus_d};
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_mode(input int m);
        return (m == 3) ? 0 : m;
    endfunction

    function automatic int exp_nwr(input int m);
        return (eff_mode(m) == 0) ? 3 : 2;
    endfunction

    function automatic logic [1:0] exp_addr(input int m, input int i);
        if (eff_mode(m) == 0) return (i == 0) ? 2'b11 : (i == 1) ? 2'b01 : 2'b10;
        return (i == 0) ? 2'b00 : 2'b11;
    endfunction

    function automatic logic [7:0] exp_data(input int m, input logic [9:0] c, input int i);
        logic [11:0] w;
        w = {c, 2'b00};
        if (eff_mode(m) == 0) return {4'h0, w[11 - 4*i -: 4]};
        return (i == 0) ? w[7:0] : {4'h0, w[11:8]};
    endfunction

    function automatic int exp_busy(input int m);
        int n;
        n = exp_nwr(m);
        return n * (E_SU + E_WR + E_HD) + (n - 1) * E_GAP +
               ((eff_mode(m) == 2) ? E_LT : (E_GAP + E_LD));
    endfunction

    // Called at a negedge: clear records, pulse start, check acceptance (R9).
    task automatic launch(input int m, input logic [9:0] c);
        nwr = 0; busy_cnt = 0; done_cnt = 0; viol = 0; ld_cnt = 0; ld_len = 0; ldlow_wr = 0;
        mode = 2'(m); code = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R10 done reached", int'(done), 1);
    endtask

    task automatic verify(input int m, input logic [9:0] c);
        int n;
        string rq;
        n = exp_nwr(m);
        rq = (m == 3) ? "R6" : (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
        chk(nwr == n, {rq, " write count"}, nwr, n);
        for (int i = 0; i < n && i < nwr; i++) begin
            chk(a_rec[i] == exp_addr(m, i), {rq, " address {a1,a0}"}, a_rec[i], exp_addr(m, i));
            chk(d_rec[i] == exp_data(m, c, i), "R2 data byte", d_rec[i], exp_data(m, c, i));
            chk(su_rec[i] == E_SU, "R7 setup cycles", su_rec[i], E_SU);
            chk(wr_rec[i] == E_WR, "R7 strobe cycles", wr_rec[i], E_WR);
            chk(hd_rec[i] == E_HD, "R7 hold cycles", hd_rec[i], E_HD);
        end
        chk(viol == 0, "R7 bus stable under cs", viol, 0);
        chk(ld_cnt == 1, {rq, " load pulse count"}, ld_cnt, 1);
        chk(ld_len == ((eff_mode(m) == 2) ? exp_busy(m) : E_LD), {rq, " load length"},
            ld_len, (eff_mode(m) == 2) ? exp_busy(m) : E_LD);
        chk(ldlow_wr == ((eff_mode(m) == 2) ? 2 : 0), {rq, " writes under load"},
            ldlow_wr, (eff_mode(m) == 2) ? 2 : 0);
        chk(busy_cnt == exp_busy(m), "R10 R8 busy cycles", busy_cnt, exp_busy(m));
        chk(done_cnt == 1 && !busy, "R10 done single", done_cnt, 1);
        chk(cs_n && wr_n && ld_n, "R11 idle strobes", {cs_n, wr_n, ld_n}, 3'b111);
        chk(bus_d == exp_data(m, c, n - 1) && {a1, a0} == exp_addr(m, n - 1),
            "R11 bus holds last", {a1, a0, bus_d}, {exp_addr(m, n - 1), exp_data(m, c, n - 1)});
    endtask

    task automatic run(input int m, input logic [9:0] c);
        launch(m, c);
        wait_done();
        verify(m, c);
    endtask

    initial begin
        void'($urandom(32'h5eed_0b1e));
        repeat (4) @(negedge clk);
        chk(!busy && !done && cs_n && wr_n && ld_n && !a0 && !a1 && bus_d == 8'h00,
            "R1 reset state", {busy, done, cs_n, wr_n, ld_n, a0, a1, bus_d},
            {7'b0011100, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && cs_n && wr_n && ld_n, "R1 R11 quiet after reset", busy, 0);

        run(0, 10'h3FF);
        run(1, 10'h000);
        run(2, 10'h201);
        run(3, 10'h155);
        run(1, 10'h2AA);

        // R9: start with different mode/code while busy is ignored.
        launch(0, 10'h0F3);
        repeat (10) @(negedge clk);
        mode = 2'd1; code = 10'h30C; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_done();
        verify(0, 10'h0F3);
        @(negedge clk);
        chk(!busy && bus_d == exp_data(0, 10'h0F3, 2), "R9 R11 ignored start left idle",
            {busy, bus_d}, {1'b0, exp_data(0, 10'h0F3, 2)});

        // R11: back-to-back start in the done cycle.
        launch(1, 10'h1C7);
        wait_done();
        verify(1, 10'h1C7);
        launch(2, 10'h38E);
        wait_done();
        verify(2, 10'h38E);

        for (int k = 0; k < 40; k++) begin
            int m;
            logic [9:0] c;
            m = int'($urandom % 4);
            c = 10'($urandom);
            @(negedge clk);
            run(m, c);
        end

        summary();
        $finish;
    end

endmodule